// File: doc/BRIEF.md
# Memory-Mapped Character Output Port

This block sits on a processor's 16-bit load/store bus and passes single characters to a downstream character sink such as a text display. Software polls a status word to see whether the sink can take another character. When it can, software stores a word to the data location. The port captures the low byte of that word and presents it to the sink with a one-cycle valid strobe.

After that store the port reports busy. It stays busy until the sink answers with a one-cycle completion pulse, which may come any number of cycles later. A store to the data location while the port is busy is dropped: it is not queued and not shown. Status reads are combinational on the address. The data location is write-only.

Top module: `disp_out_port`

## Requirements
- R1: After reset the ready flag is one (status reads 0x8000), `dev_valid_o` is low, and no character is pending.
- R2: With the address at 0xFE04, `bus_rdata_o` shows the ready flag in bit 15 and zeros in bits 14:0. Any other address, including the write-only data address 0xFE06, reads 0x0000.
- R3: A write to 0xFE06 while ready is one clears the ready flag from the next cycle onward.
- R4: An accepted write drives `dev_valid_o` high for exactly one cycle, starting the cycle after the write. `dev_char_o` carries bits 7:0 of the written word. Bits 15:8 of the word have no effect.
- R5: A write to 0xFE06 while ready is zero is discarded. No valid strobe follows, `dev_char_o` keeps its previous value, and ready stays zero.
- R6: A `dev_done_i` pulse while ready is zero sets ready to one from the next cycle. Ready stays zero until that pulse arrives, however long the sink takes.
- R7: A write to any address other than 0xFE06, including the status address, changes neither the ready flag nor the device outputs.
- R8: A `dev_done_i` pulse while ready is one has no effect. If it coincides with an accepted data write, the write takes effect and ready becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 16 | Bus address |
| bus_wdata_i | input | 16 | Bus write data |
| bus_we_i | input | 1 | Bus write strobe, one cycle per store |
| bus_rdata_o | output | 16 | Read data for the current address |
| dev_valid_o | output | 1 | One-cycle strobe that a new character is present |
| dev_char_o | output | 8 | Character presented to the sink |
| dev_done_i | input | 1 | One-cycle pulse from the sink that it has finished |

## Verification
The accept path is swept with every one of the 256 character codes. Each code is written with a varying upper byte, which separates use of the low byte from leakage of bits 15:8. After every accepted character the bench stores a different code while the port is busy. This separates a dropped write from one that is queued or overwrites the pending character. The completion pulse arrives after latencies of zero to three idle cycles, which shows that ready waits for the pulse rather than a fixed delay. Separate sweeps write to and read from many addresses to show the decode is exact, and stray or coincident completion pulses are sent while the port is idle.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned CHAR_W = 8;
  localparam logic [BUS_W-1:0] STAT_ADDR = 16'hFE04;
  localparam logic [BUS_W-1:0] DATA_ADDR = 16'hFE06;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } port_sel_e;
endpackage

// File: rtl/disp_addr_dec.sv
module disp_addr_dec
  import disp_pkg::*;
#(
  parameter int unsigned          BUS_W     = 16,
  parameter logic [BUS_W-1:0]     STAT_ADDR = 16'hFE04,
  parameter logic [BUS_W-1:0]     DATA_ADDR = 16'hFE06
) (
  input  logic [BUS_W-1:0] addr_i,
  input  logic             we_i,
  output port_sel_e        sel_o,
  output logic             wr_data_o
);
  always_comb begin
    if (addr_i == STAT_ADDR)      sel_o = SEL_STAT;
    else if (addr_i == DATA_ADDR) sel_o = SEL_DATA;
    else                          sel_o = SEL_NONE;
  end

  assign wr_data_o = we_i && (sel_o == SEL_DATA);
endmodule

// File: rtl/disp_ready_ctl.sv
module disp_ready_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_data_i,
  input  logic done_i,
  output logic ready_o,
  output logic accept_o
);
  logic ready_q;

  assign accept_o = wr_data_i && ready_q;
  assign ready_o  = ready_q;

  // accepted write wins over a coincident done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ready_q <= 1'b1;
    else if (accept_o) ready_q <= 1'b0;
    else if (done_i)   ready_q <= 1'b1;
  end

  assert_accept_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && ready_q) |=> !ready_q);

  assert_busy_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && !ready_q && !done_i) |=> !ready_q);

  assert_done_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_q && done_i) |=> ready_q);
endmodule

// File: rtl/disp_char_launch.sv
module disp_char_launch #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] char_o
);
  logic              valid_q;
  logic [CHAR_W-1:0] char_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= accept_i;
      if (accept_i) char_q <= char_i;
    end
  end

  assign valid_o = valid_q;
  assign char_o  = char_q;

  assert_launch_char_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (valid_q && char_q == $past(char_i)));

  assert_char_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(char_q));
endmodule

// File: rtl/disp_out_port.sv
module disp_out_port
  import disp_pkg::*;
#(
  parameter int unsigned      BUS_W     = 16,
  parameter int unsigned      CHAR_W    = 8,
  parameter logic [BUS_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [BUS_W-1:0] DATA_ADDR = 16'hFE06
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  input  logic              bus_we_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              dev_valid_o,
  output logic [CHAR_W-1:0] dev_char_o,
  input  logic              dev_done_i
);
  localparam int unsigned READY_POS = BUS_W - 1;

  port_sel_e sel;
  logic      wr_data;
  logic      ready;
  logic      accept;

  disp_addr_dec #(
    .BUS_W    (BUS_W),
    .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .sel_o    (sel),
    .wr_data_o(wr_data)
  );

  disp_ready_ctl u_rdy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_data_i(wr_data),
    .done_i   (dev_done_i),
    .ready_o  (ready),
    .accept_o (accept)
  );

  disp_char_launch #(.CHAR_W(CHAR_W)) u_launch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .char_i  (bus_wdata_i[CHAR_W-1:0]),
    .valid_o (dev_valid_o),
    .char_o  (dev_char_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (sel == SEL_STAT) bus_rdata_o[READY_POS] = ready;
  end

  assert_valid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o |=> !dev_valid_o);

  assert_valid_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o |-> !ready);

  assert_other_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i != DATA_ADDR && !dev_done_i) |=>
      (!dev_valid_o && $stable(dev_char_o) && ready == $past(ready)));

  assert_idle_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && dev_done_i && !wr_data) |=> (ready && !dev_valid_o));
endmodule

// File: tb/sim_disp_out_port.sv
`timescale 1ns/1ps
module sim_disp_out_port;
  localparam logic [15:0] STAT = 16'hFE04;
  localparam logic [15:0] DATA = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic        done = 1'b0;
  logic [15:0] rdata;
  logic        valid;
  logic [7:0]  chr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  disp_out_port u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_we_i   (we),
    .bus_rdata_o(rdata),
    .dev_valid_o(valid),
    .dev_char_o (chr),
    .dev_done_i (done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // leaves addr at status, we low, sampled 1ns after the negedge
  task automatic step_idle();
    @(negedge clk);
    we = 1'b0; done = 1'b0; addr = STAT;
    #1;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] last;
    addr = STAT;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 status", rdata, 16'h8000);
    chk("R1 valid", {15'b0, valid}, 16'h0);
    chk("R1 char", {8'b0, chr}, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: read decode sweep while ready
    for (int k = 0; k < 64; k++) begin
      logic [15:0] a;
      a = (k < 4) ? (16'hFE03 + 16'(k)) : 16'(k * 1031);
      addr = a; #1;
      chk("R2 read", rdata, (a == STAT) ? 16'h8000 : 16'h0000);
    end
    addr = DATA; #1;
    chk("R2 data addr reads zero", rdata, 16'h0);

    // R7: writes elsewhere have no effect
    for (int k = 0; k < 64; k++) begin
      logic [15:0] a;
      a = (k < 6) ? (16'hFE02 + 16'(k)) : 16'(k * 977 + 5);
      if (a == DATA) a = 16'hFE07;
      @(negedge clk);
      addr = a; wdata = 16'(k * 13 + 7); we = 1'b1;
      step_idle();
      chk("R7 valid", {15'b0, valid}, 16'h0);
      chk("R7 ready", rdata, 16'h8000);
      chk("R7 char", {8'b0, chr}, 16'h0);
    end

    // R8: stray done while ready
    @(negedge clk); done = 1'b1;
    step_idle();
    chk("R8 idle done ready", rdata, 16'h8000);
    chk("R8 idle done valid", {15'b0, valid}, 16'h0);

    // main sweep: every character, varied upper byte, busy write, variable latency
    for (int c = 0; c < 256; c++) begin
      logic [7:0] hi;
      int lat;
      hi = 8'((c * 37 + 91) & 255);
      lat = c % 4;
      @(negedge clk);
      addr = DATA; wdata = {hi, 8'(c)}; we = 1'b1;
      step_idle();
      chk("R4 valid", {15'b0, valid}, 16'h1);
      chk("R4 char", {8'b0, chr}, 16'(c));
      chk("R3 ready cleared", rdata, 16'h0);
      // busy write of another code, discarded
      @(negedge clk);
      addr = DATA; wdata = {~hi, ~8'(c)}; we = 1'b1;
      #1;
      chk("R4 valid one cycle", {15'b0, valid}, 16'h0);
      step_idle();
      chk("R5 no valid", {15'b0, valid}, 16'h0);
      chk("R5 char kept", {8'b0, chr}, 16'(c));
      chk("R5 still busy", rdata, 16'h0);
      for (int d = 0; d < lat; d++) begin
        step_idle();
        chk("R6 waits for done", rdata, 16'h0);
      end
      @(negedge clk); done = 1'b1;
      step_idle();
      chk("R6 ready after done", rdata, 16'h8000);
      chk("R6 no valid", {15'b0, valid}, 16'h0);
    end
    last = 8'hFF;

    // R8: done coincident with accepted write
    @(negedge clk);
    addr = DATA; wdata = 16'hA55A; we = 1'b1; done = 1'b1;
    step_idle();
    chk("R8 write wins valid", {15'b0, valid}, 16'h1);
    chk("R8 write wins char", {8'b0, chr}, 16'h005A);
    chk("R8 write wins ready", rdata, 16'h0);
    chk("R4 last char replaced", {8'b0, chr}, (last == 8'h5A) ? 16'hFFFF : 16'h005A);
    // R7: status write while busy does not set ready
    @(negedge clk);
    addr = STAT; wdata = 16'hFFFF; we = 1'b1;
    step_idle();
    chk("R7 status write busy", rdata, 16'h0);
    @(negedge clk); done = 1'b1;
    step_idle();
    chk("R6 final ready", rdata, 16'h8000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule